// File: doc/BRIEF.md
# Slave Serial Audio Output Formatter

This block turns a stereo PCM sample pair into a serial bit stream on one data pin. It never generates clocks: the bit clock and the word select are supplied from outside. Both are oversampled by the block's own system clock, which must run several times faster than the bit clock. Every change of the data pin follows a detected falling edge of the bit clock. A static format input picks one of two framings: I2S, where the word starts one bit clock after the word select change, or MSB-justified, where the word starts on the same edge as the word select change.

The upstream filter presents a left and a right word on parallel inputs. The block captures both at the start of every frame, which is the word select edge that opens the left channel. It sends the left word at once and keeps the right word for the following half-frame. Words are sent most significant bit first. Any bit clock periods after the last bit carry zero. A mute input forces the pin low while serialisation carries on in the background.

Top module: `pcm_serial_tx`

## Requirements
- R1: While reset is low, and after it until the first left-channel word select edge, `sd_o` is 0.
- R2: `sd_o` changes only SYNC_STAGES+1 system clock cycles after a bit clock falling edge or a change of mute. It is otherwise stable across the whole bit clock period.
- R3: With `fmt_i` = 0 (I2S), word select low marks the left channel. The MSB appears on the bit clock falling edge after the edge on which word select changed.
- R4: With `fmt_i` = 1 (MSB-justified), word select high marks the left channel. The MSB appears on the same falling edge on which word select changed.
- R5: Each word is WORD_W bits, sent MSB first, one bit per bit clock falling edge. Every later bit period before the next word select change is 0.
- R6: In I2S mode the bit period that starts at a word select change carries the previous word's LSB when a half-frame has exactly WORD_W bit periods, and 0 when it is longer.
- R7: Both words are taken from `left_i` and `right_i` at the left-channel word select edge. Changing `right_i` after that edge does not alter the right word sent in that frame.
- R8: While mute is high, `sd_o` is 0. Shifting continues, so after mute falls the output resumes with the bit due in that position of the current word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | External bit clock |
| ws_i | input | 1 | External word select, changing on bit clock falling edges |
| fmt_i | input | 1 | Framing: 0 = I2S, 1 = MSB-justified (static) |
| mute_i | input | 1 | Forces the data output low |
| left_i | input | WORD_W | Left PCM word from the filter |
| right_i | input | WORD_W | Right PCM word from the filter |
| sd_o | output | 1 | Serial data output |

## Verification
A bit clock falling edge, and any mute change, reaches `sd_o` after exactly SYNC_STAGES+1 system clock edges: the synchroniser stages plus the edge-detect and output register. That is three cycles by default. The bench drives each bit clock fall on a falling system clock edge and samples `sd_o` on the third falling edge after it. It samples again just before the next fall to confirm the bit held (R2). Expected bits come from a slot model that the bench keeps per half-frame. The model tracks the carried I2S bit and the latched right word, so each check lands in the bit period its requirement names.

// File: rtl/pcm_stx_pkg.sv
// Shared definitions for the serial PCM transmitter.
// Assumes: nothing beyond IEEE 1800-2017.
package pcm_stx_pkg;

    // Framing selected by the static format input.
    typedef enum logic {
        FMT_I2S   = 1'b0,
        FMT_MSB_J = 1'b1
    } frame_fmt_e;

    // Word select level that marks the left channel for a given framing.
    function automatic logic left_ws_level(input frame_fmt_e fmt);
        return (fmt == FMT_MSB_J) ? 1'b1 : 1'b0;
    endfunction

endpackage

// File: rtl/pcm_stx_sync.sv
// Multi-bit level synchroniser for asynchronous control inputs.
// Assumes: each bit is an independent slow level (bit clock, word select, mute),
// so skew between bits of one or two cycles is harmless.
module pcm_stx_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    generate
        if (STAGES == 0) begin : g_bypass
            // Pass-through when the inputs are already synchronous.
            assign q_o = d_i;
        end else begin : g_chain
            logic [WIDTH-1:0] stage_q [STAGES];

            // Shift each input through STAGES flops, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
                end else begin
                    stage_q[0] <= d_i;
                    for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
                end
            end

            assign q_o = stage_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/pcm_stx_edges.sv
// Bit clock falling-edge and word select transition detector.
// Assumes: synchronised inputs; word select only changes with a bit clock fall,
// so it is compared at falls only.
module pcm_stx_edges
    import pcm_stx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_s,
    input  logic       ws_s,
    input  frame_fmt_e fmt,
    output logic       sck_fall,
    output logic       ws_edge,
    output logic       left_start
);

    logic sck_q;
    logic ws_q;

    // Remember the previous bit clock level every system clock.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    assign sck_fall = sck_q & ~sck_s;

    // Word select level as seen at the last bit clock fall.
    always_ff @(posedge clk) begin
        if (!rst_n)        ws_q <= 1'b0;
        else if (sck_fall) ws_q <= ws_s;
    end

    // A transition on a fall opens a new half-frame.
    always_comb begin
        ws_edge    = sck_fall && (ws_s != ws_q);
        left_start = ws_edge && (ws_s == left_ws_level(fmt));
    end

endmodule

// File: rtl/pcm_stx_latch.sv
// Frame sample latch: captures the stereo pair at the left-channel start.
// Assumes: the filter holds left_i/right_i valid around the left word select edge.
module pcm_stx_latch #(
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              left_start,
    input  logic [WORD_W-1:0] left_i,
    input  logic [WORD_W-1:0] right_i,
    output logic [WORD_W-1:0] load_word
);

    logic [WORD_W-1:0] right_hold;

    // Keep the right word of the pair until its half-frame begins.
    always_ff @(posedge clk) begin
        if (!rst_n)          right_hold <= '0;
        else if (left_start) right_hold <= right_i;
    end

    // Left is used straight away, right comes from the hold register.
    always_comb begin
        load_word = left_start ? left_i : right_hold;
    end

endmodule

// File: rtl/pcm_stx_shift.sv
// Output shift register with format-dependent load and mute gating.
// Assumes: sck_fall and ws_edge are single-cycle strobes from the edge detector.
module pcm_stx_shift
    import pcm_stx_pkg::*;
#(
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_fall,
    input  logic              ws_edge,
    input  frame_fmt_e        fmt,
    input  logic              mute_s,
    input  logic [WORD_W-1:0] load_word,
    output logic              sd_o
);

    logic [WORD_W-1:0] shreg_q, shreg_n;
    logic              bit_q, bit_n;
    logic              sd_q;

    // Next shift state and data bit; zeros fill in behind the LSB.
    always_comb begin
        shreg_n = shreg_q;
        bit_n   = bit_q;
        if (sck_fall) begin
            if (ws_edge && fmt == FMT_MSB_J) begin
                bit_n   = load_word[WORD_W-1];
                shreg_n = {load_word[WORD_W-2:0], 1'b0};
            end else if (ws_edge) begin
                bit_n   = shreg_q[WORD_W-1];
                shreg_n = load_word;
            end else begin
                bit_n   = shreg_q[WORD_W-1];
                shreg_n = {shreg_q[WORD_W-2:0], 1'b0};
            end
        end
    end

    // Register shift state and the current unmuted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
            bit_q   <= 1'b0;
        end else begin
            shreg_q <= shreg_n;
            bit_q   <= bit_n;
        end
    end

    // Registered output, forced low by mute.
    always_ff @(posedge clk) begin
        if (!rst_n) sd_q <= 1'b0;
        else        sd_q <= bit_n & ~mute_s;
    end

    assign sd_o = sd_q;

endmodule

// File: rtl/pcm_serial_tx.sv
// Slave serial PCM transmitter (I2S / MSB-justified), top level.
// Assumes: clk at least ~6x the bit clock; bit clock <= 128x word select rate;
// word select changes on bit clock falls; 50% word select duty in MSB-justified mode.
module pcm_serial_tx
    import pcm_stx_pkg::*;
#(
    parameter int WORD_W      = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              ws_i,
    input  logic              fmt_i,
    input  logic              mute_i,
    input  logic [WORD_W-1:0] left_i,
    input  logic [WORD_W-1:0] right_i,
    output logic              sd_o
);

    localparam int N_CTRL = 3;

    logic [N_CTRL-1:0] ctrl_raw, ctrl_s;
    logic              sck_s, ws_s, mute_s;
    logic              sck_fall, ws_edge, left_start;
    logic [WORD_W-1:0] load_word;
    frame_fmt_e        fmt;

    assign ctrl_raw = {mute_i, ws_i, sck_i};
    assign sck_s    = ctrl_s[0];
    assign ws_s     = ctrl_s[1];
    assign mute_s   = ctrl_s[2];
    assign fmt      = frame_fmt_e'(fmt_i);

    pcm_stx_sync #(.STAGES(SYNC_STAGES), .WIDTH(N_CTRL)) sync_i (
        .clk(clk), .rst_n(rst_n), .d_i(ctrl_raw), .q_o(ctrl_s)
    );

    pcm_stx_edges edges_i (
        .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .ws_s(ws_s), .fmt(fmt),
        .sck_fall(sck_fall), .ws_edge(ws_edge), .left_start(left_start)
    );

    pcm_stx_latch #(.WORD_W(WORD_W)) latch_i (
        .clk(clk), .rst_n(rst_n), .left_start(left_start),
        .left_i(left_i), .right_i(right_i), .load_word(load_word)
    );

    pcm_stx_shift #(.WORD_W(WORD_W)) shift_i (
        .clk(clk), .rst_n(rst_n), .sck_fall(sck_fall), .ws_edge(ws_edge),
        .fmt(fmt), .mute_s(mute_s), .load_word(load_word), .sd_o(sd_o)
    );

endmodule

// File: rtl/pcm_serial_tx_chk.sv
// Property checker bound to pcm_serial_tx.
// Assumes: connected to the top's internal strobes via the bind below.
module pcm_serial_tx_chk #(
    parameter int WORD_W = 20
) (
    input logic clk,
    input logic rst_n,
    input logic sd_o,
    input logic mute_s,
    input logic sck_fall,
    input logic ws_edge
);

    localparam int CW  = $clog2(WORD_W + 3);
    localparam int LIM = WORD_W + 2;

    logic [CW-1:0] slot_q;

    // Count bit clock falls since the last word select change, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                      slot_q <= '0;
        else if (sck_fall && ws_edge)    slot_q <= '0;
        else if (sck_fall && slot_q < CW'(LIM)) slot_q <= slot_q + 1'b1;
    end

    // R1: reset drives the output low.
    p_reset_low_r1: assert property (@(posedge clk) !rst_n |=> !sd_o);

    // R8: muted output is low.
    p_mute_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mute_s |=> !sd_o);

    // R2: no fall and no mute activity means the output holds.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_fall && !mute_s && !$past(mute_s)) |=> $stable(sd_o));

    // R5: slots past the word (and the I2S delay) carry zero.
    p_tail_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_fall && !ws_edge && (slot_q >= CW'(WORD_W))) |=> !sd_o);

endmodule

bind pcm_serial_tx pcm_serial_tx_chk #(.WORD_W(WORD_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .sd_o(sd_o), .mute_s(mute_s),
    .sck_fall(sck_fall), .ws_edge(ws_edge)
);

// File: tb/pcm_serial_tx_tb_top.sv
`timescale 1ns/1ps
// Directed bench for pcm_serial_tx: one task per scenario.
module pcm_serial_tx_tb_top;

    localparam int W   = 20;
    localparam int LAT = 3;   // SYNC_STAGES + 1

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sck = 1'b1;
    logic         ws = 1'b1;
    logic         fmt = 1'b0;
    logic         mute = 1'b0;
    logic [W-1:0] left_w = '0;
    logic [W-1:0] right_w = '0;
    logic         sd;

    int  n_chk = 0;
    int  n_err = 0;
    int  cyc = 0;
    bit  done = 0;
    logic carry = 1'b0;

    always #2.5 clk = ~clk;

    pcm_serial_tx #(.WORD_W(W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .ws_i(ws), .fmt_i(fmt),
        .mute_i(mute), .left_i(left_w), .right_i(right_w), .sd_o(sd)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_err++;
            $display("FAIL watchdog: cycles=%0d expected < 150000", cyc);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
            $finish;
        end
    end

    task automatic chk(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: sd_o=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Send one half-frame of bpc bit periods and check every slot.
    task automatic half(input logic ws_val, input logic [W-1:0] word, input int bpc,
                        input int mlo, input int mhi, input int corrupt_at,
                        input string req);
        logic e;
        for (int j = 0; j < bpc; j++) begin
            sck = 1'b0;
            if (j == 0) ws = ws_val;
            mute = (j >= mlo && j <= mhi);
            if (j == corrupt_at) right_w = ~right_w;
            if (mute) e = 1'b0;
            else if (fmt) e = (j < W) ? word[W-1-j] : 1'b0;
            else if (j == 0) e = carry;
            else e = (j <= W) ? word[W-j] : 1'b0;
            repeat (LAT) @(negedge clk);
            chk(sd, e, req);
            sck = 1'b1;
            repeat (4) @(negedge clk);
            chk(sd, e, "R2 hold");
        end
        mute = 1'b0;
        carry = (bpc == W) ? word[0] : 1'b0;
    endtask

    task automatic frame(input logic [W-1:0] l, input logic [W-1:0] r, input int bpc,
                         input int mlo, input int mhi, input int corrupt_at,
                         input string req);
        logic lws;
        lws = fmt;
        left_w = l;
        right_w = r;
        half(lws, l, bpc, mlo, mhi, corrupt_at, req);
        half(~lws, r, bpc, -1, -2, -1, req);
    endtask

    // R1: reset, then a lead-in half-frame with no data yet.
    task automatic t_reset(input logic f);
        @(negedge clk);
        rst_n = 1'b0;
        fmt = f;
        sck = 1'b1;
        ws = f ? 1'b0 : 1'b1;
        mute = 1'b0;
        left_w = 20'hFFFFF;
        right_w = 20'hFFFFF;
        repeat (4) @(negedge clk);
        chk(sd, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(sd, 1'b0, "R1 after reset");
        carry = 1'b0;
        half(ws, '0, 24, -1, -2, -1, "R1 lead-in");
    endtask

    // R3/R5: I2S with slack slots.
    task automatic t_i2s_basic;
        t_reset(1'b0);
        frame(20'hA5C3F, 20'h5A3C1, 32, -1, -2, -1, "R3 R5 i2s");
        frame(20'h80001, 20'h7FFFE, 24, -1, -2, -1, "R3 R5 i2s");
    endtask

    // R6: I2S with half-frame equal to the word, LSB spills into next slot 0.
    task automatic t_i2s_tight;
        frame(20'h00001, 20'hFFFFF, W, -1, -2, -1, "R6 i2s tight");
        frame(20'h13579, 20'h24681, W, -1, -2, -1, "R6 i2s tight");
    endtask

    // R4/R5: MSB-justified.
    task automatic t_msbj;
        t_reset(1'b1);
        frame(20'hC0FFE, 20'h0BEEF, 32, -1, -2, -1, "R4 R5 msbj");
        frame(20'h00001, 20'h80000, W, -1, -2, -1, "R4 R5 msbj tight");
    endtask

    // R7: right_i changes after the frame start are not sent.
    task automatic t_latch;
        frame(20'h3C3C3, 20'h96969, 24, -1, -2, 3, "R7 latch");
    endtask

    // R8: mute over part of the left word, then resume.
    task automatic t_mute;
        frame(20'hFFFFF, 20'hFFFFF, 24, 2, 6, -1, "R8 mute");
        frame(20'hFFFFF, 20'hAAAAA, 24, 0, 23, -1, "R8 mute full");
    endtask

    initial begin
        t_i2s_basic();
        t_i2s_tight();
        t_latch();
        t_mute();
        t_msbj();
        t_latch();
        t_mute();
        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule